// File: doc/BRIEF.md
# Memory Connectivity and Retention Tester

This block is a hardware test sequencer. It drives a simple single-port memory through one request strobe with write enable, address, write data, read data and a read-valid return. After a start pulse it runs four phases in a fixed order and reports the outcome. The first phase checks the data lines with a walking single-bit pattern on one word. The second checks the address lines by writing at power-of-two offsets. The third and fourth check that every cell of the tested region can hold both a 0 and a 1. They do this by filling the region with its own addresses and then with the complement of those addresses, reading each value back after the fill.

The tested region runs from word 0 to word `REGION_WORDS-1`. It need not be a power of two. On the first wrong read value the sequencer stops and holds the phase, the address, the expected word and the word read. A bring-up or self-test controller pulses start, waits for done, and then reads pass and the failure record.

Top module: `memtest_engine`

## Requirements
- R1: Phase code 0 starts with walking ones at the fixed address `DBUS_ADDR`. It writes a word with only bit 0 set, then only bit 1, and so on up to bit DW-1. Each write is followed at once by a read of that address, and the read value is compared with the word written.
- R2: After the walking ones, phase code 0 runs walking zeros at the same address. Each word has exactly one 0 bit, at bit 0, then bit 1 and so on, and each write is again followed by its read and compare.
- R3: Phase code 1 first writes the base pattern to offset 0 and to every power-of-two offset 2^k below `REGION_WORDS`. The base pattern has every odd bit set (0xAA for DW=8), and the test pattern is its complement (0x55). Then, for each power-of-two offset in turn, the phase writes the test pattern there. It reads offset 0 and every other power-of-two offset and expects the base pattern at each. It then writes the base pattern back to that offset.
- R4: Phase code 2 writes every word of the region with its own address, zero-extended or truncated to DW bits. It then reads every word back and compares it.
- R5: Phase code 3 repeats the fill and read-back with the bitwise complement of the address-derived value.
- R6: On the first read that differs from its expected value, the sequencer issues no further requests. It holds that phase code, address, expected value and read value on the fail outputs, with done=1 and pass=0.
- R7: When all four phases complete with no mismatch, done=1 and pass=1, and every fail output reads 0.
- R8: At most one read is outstanding. After a read request, no request is issued until read valid returns, so any fixed or varying read latency of one cycle or more gives the same result.
- R9: Every request addresses a word below `REGION_WORDS`.
- R10: A start pulse during a run has no effect. A start pulse after done clears done, pass and the fail outputs and begins a new run from phase code 0.
- R11: After reset, done=0, pass=0 and no request is issued until start is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| mem_req_o | output | 1 | Memory request, high for one cycle per access |
| mem_we_o | output | 1 | 1 = write, 0 = read, valid with mem_req_o |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with mem_rvalid_i |
| mem_rvalid_i | input | 1 | Read data return strobe |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with no mismatch |
| fail_phase_o | output | 2 | Phase code of the first mismatch |
| fail_addr_o | output | AW | Address of the first mismatch |
| fail_exp_o | output | DW | Expected word at the first mismatch |
| fail_act_o | output | DW | Word read at the first mismatch |

## Verification
The bench builds the block with AW=10, DW=8 and REGION_WORDS=300. Because the address is wider than the data, the address-derived fill value truncates, so word 290 carries 0x22. Because the region is not a power of two, the highest tested offset is 256 and words above it exist. The bench's memory model can add stuck data bits, an ignored address line, single-cell stuck bits and a latency that alternates between 1 and 4 cycles. Each fault is placed so that a chosen phase is the first to see it, which checks the exact phase, address, expected and actual values recorded.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [1:0] {
    PH_DBUS  = 2'd0,
    PH_ABUS  = 2'd1,
    PH_AFILL = 2'd2,
    PH_IFILL = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } state_e;

endpackage

// File: rtl/mt_cursor_step.sv
// Computes the position of the next access in the fixed test sequence.
module mt_cursor_step
  import mt_pkg::*;
#(
  parameter int DW           = 8,
  parameter int REGION_WORDS = 300,
  parameter int NA           = 9,
  parameter int CW           = 10
) (
  input  phase_e          phase_i,
  input  logic            sub_i,
  input  logic [CW-1:0]   i_i,
  input  logic [CW-1:0]   j_i,
  output phase_e          phase_o,
  output logic            sub_o,
  output logic [CW-1:0]   i_o,
  output logic [CW-1:0]   j_o,
  output logic            last_o
);
  localparam logic [CW-1:0] BIT_LAST  = CW'(DW - 1);
  localparam logic [CW-1:0] LINE_LAST = CW'(NA);
  localparam logic [CW-1:0] STEP_LAST = CW'(NA + 2);
  localparam logic [CW-1:0] WORD_LAST = CW'(REGION_WORDS - 1);

  always_comb begin
    phase_o = phase_i;
    sub_o   = sub_i;
    i_o     = i_i;
    j_o     = j_i;
    last_o  = 1'b0;
    case (phase_i)
      PH_DBUS: begin
        if (j_i == '0) begin
          j_o = CW'(1);
        end else begin
          j_o = '0;
          if (i_i < BIT_LAST) begin
            i_o = i_i + CW'(1);
          end else begin
            i_o = '0;
            if (!sub_i) begin
              sub_o = 1'b1;
            end else begin
              phase_o = PH_ABUS;
              sub_o   = 1'b0;
            end
          end
        end
      end
      PH_ABUS: begin
        if (!sub_i) begin
          if (i_i < LINE_LAST) begin
            i_o = i_i + CW'(1);
          end else begin
            sub_o = 1'b1;
            i_o   = CW'(1);
            j_o   = '0;
          end
        end else if (j_i == STEP_LAST) begin
          j_o = '0;
          if (i_i < LINE_LAST) begin
            i_o = i_i + CW'(1);
          end else begin
            phase_o = PH_AFILL;
            sub_o   = 1'b0;
            i_o     = '0;
          end
        end else if (j_i == i_i) begin
          j_o = j_i + CW'(2);  // skip reading the line under test
        end else begin
          j_o = j_i + CW'(1);
        end
      end
      default: begin
        if (i_i < WORD_LAST) begin
          i_o = i_i + CW'(1);
        end else begin
          i_o = '0;
          if (!sub_i) begin
            sub_o = 1'b1;
          end else if (phase_i == PH_AFILL) begin
            phase_o = PH_IFILL;
            sub_o   = 1'b0;
          end else begin
            last_o = 1'b1;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/mt_op_decode.sv
// Turns a sequence position into an access: read or write, address and data.
module mt_op_decode
  import mt_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 8,
  parameter int NA        = 9,
  parameter int CW        = 10,
  parameter int DBUS_ADDR = 0
) (
  input  phase_e          phase_i,
  input  logic            sub_i,
  input  logic [CW-1:0]   i_i,
  input  logic [CW-1:0]   j_i,
  output logic            is_read_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o
);
  localparam logic [CW-1:0] STEP_LAST = CW'(NA + 2);

  function automatic logic [DW-1:0] odd_bits();
    logic [DW-1:0] p;
    for (int k = 0; k < DW; k++) p[k] = (k % 2) == 1;
    return p;
  endfunction

  localparam logic [DW-1:0] BASE_PAT = odd_bits();
  localparam logic [DW-1:0] TEST_PAT = ~BASE_PAT;
  localparam logic [DW-1:0] ONE_DW   = DW'(1);
  localparam logic [AW-1:0] ONE_AW   = AW'(1);

  function automatic logic [AW-1:0] idx_to_addr(input logic [CW-1:0] v);
    logic [CW+AW-1:0] e;
    e = {{AW{1'b0}}, v};
    return e[AW-1:0];
  endfunction

  function automatic logic [DW-1:0] addr_to_data(input logic [AW-1:0] a);
    logic [AW+DW-1:0] e;
    e = {{DW{1'b0}}, a};
    return e[DW-1:0];
  endfunction

  // line index 0 -> offset 0, index k -> offset 2^(k-1)
  function automatic logic [AW-1:0] line_addr(input logic [CW-1:0] k);
    if (k == '0) return '0;
    return ONE_AW << (k - CW'(1));
  endfunction

  logic [DW-1:0] walk;
  logic [AW-1:0] fill_addr;
  assign walk      = ONE_DW << i_i;
  assign fill_addr = idx_to_addr(i_i);

  always_comb begin
    is_read_o = 1'b0;
    addr_o    = '0;
    data_o    = '0;
    case (phase_i)
      PH_DBUS: begin
        addr_o    = AW'(DBUS_ADDR);
        data_o    = sub_i ? ~walk : walk;
        is_read_o = (j_i != '0);
      end
      PH_ABUS: begin
        data_o = BASE_PAT;
        if (!sub_i) begin
          addr_o = line_addr(i_i);
        end else if (j_i == '0) begin
          addr_o = line_addr(i_i);
          data_o = TEST_PAT;
        end else if (j_i == STEP_LAST) begin
          addr_o = line_addr(i_i);
        end else begin
          addr_o    = line_addr(j_i - CW'(1));
          is_read_o = 1'b1;
        end
      end
      default: begin
        addr_o    = fill_addr;
        data_o    = (phase_i == PH_IFILL) ? ~addr_to_data(fill_addr)
                                          : addr_to_data(fill_addr);
        is_read_o = sub_i;
      end
    endcase
  end

endmodule

// File: rtl/mt_fail_latch.sv
// Compares returned data and holds the record of the first mismatch.
module mt_fail_latch #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            clear_i,
  input  logic            check_i,
  input  logic [1:0]      phase_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   exp_i,
  input  logic [DW-1:0]   act_i,
  output logic            mismatch_o,
  output logic [1:0]      phase_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   exp_o,
  output logic [DW-1:0]   act_o
);
  assign mismatch_o = check_i && (act_i != exp_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      phase_o <= '0;
      addr_o  <= '0;
      exp_o   <= '0;
      act_o   <= '0;
    end else if (mismatch_o) begin
      phase_o <= phase_i;
      addr_o  <= addr_i;
      exp_o   <= exp_i;
      act_o   <= act_i;
    end
  end

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
  import mt_pkg::*;
#(
  parameter int AW           = 10,
  parameter int DW           = 8,
  parameter int REGION_WORDS = 300,
  parameter int DBUS_ADDR    = 0
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_rvalid_i,
  output logic            done_o,
  output logic            pass_o,
  output logic [1:0]      fail_phase_o,
  output logic [AW-1:0]   fail_addr_o,
  output logic [DW-1:0]   fail_exp_o,
  output logic [DW-1:0]   fail_act_o
);
  localparam int NA     = $clog2(REGION_WORDS);
  localparam int MAX_A  = (REGION_WORDS > DW) ? REGION_WORDS : DW;
  localparam int MAXCNT = (MAX_A > NA + 3) ? MAX_A : NA + 3;
  localparam int CW     = $clog2(MAXCNT + 1);

  state_e        state_q;
  phase_e        phase_q, phase_n;
  logic          sub_q, sub_n;
  logic [CW-1:0] i_q, i_n, j_q, j_n;
  logic          step_last;

  logic          op_read;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [DW-1:0] exp_q;
  logic          mismatch;
  logic          start_ok;

  mt_cursor_step #(
    .DW(DW), .REGION_WORDS(REGION_WORDS), .NA(NA), .CW(CW)
  ) step_i (
    .phase_i(phase_q), .sub_i(sub_q), .i_i(i_q), .j_i(j_q),
    .phase_o(phase_n), .sub_o(sub_n), .i_o(i_n), .j_o(j_n),
    .last_o(step_last)
  );

  mt_op_decode #(
    .AW(AW), .DW(DW), .NA(NA), .CW(CW), .DBUS_ADDR(DBUS_ADDR)
  ) dec_i (
    .phase_i(phase_q), .sub_i(sub_q), .i_i(i_q), .j_i(j_q),
    .is_read_o(op_read), .addr_o(op_addr), .data_o(op_data)
  );

  assign start_ok = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  mt_fail_latch #(.AW(AW), .DW(DW)) latch_i (
    .clk_i(clk_i), .rst_i(rst_i), .clear_i(start_ok),
    .check_i(state_q == ST_WAIT && mem_rvalid_i),
    .phase_i(phase_q), .addr_i(mem_addr_o), .exp_i(exp_q), .act_i(mem_rdata_i),
    .mismatch_o(mismatch),
    .phase_o(fail_phase_o), .addr_o(fail_addr_o),
    .exp_o(fail_exp_o), .act_o(fail_act_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_DBUS;
      sub_q       <= 1'b0;
      i_q         <= '0;
      j_q         <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      exp_q       <= '0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
    end else begin
      mem_req_o <= 1'b0;
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            state_q <= ST_ISSUE;
            phase_q <= PH_DBUS;
            sub_q   <= 1'b0;
            i_q     <= '0;
            j_q     <= '0;
            done_o  <= 1'b0;
            pass_o  <= 1'b0;
          end
        end
        ST_ISSUE: begin
          mem_req_o   <= 1'b1;
          mem_we_o    <= !op_read;
          mem_addr_o  <= op_addr;
          mem_wdata_o <= op_read ? '0 : op_data;
          exp_q       <= op_data;
          if (op_read) begin
            state_q <= ST_WAIT;
          end else begin
            phase_q <= phase_n;
            sub_q   <= sub_n;
            i_q     <= i_n;
            j_q     <= j_n;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (mismatch) begin
              state_q <= ST_DONE;
              done_o  <= 1'b1;
              pass_o  <= 1'b0;
            end else if (step_last) begin
              state_q <= ST_DONE;
              done_o  <= 1'b1;
              pass_o  <= 1'b1;
            end else begin
              state_q <= ST_ISSUE;
              phase_q <= phase_n;
              sub_q   <= sub_n;
              i_q     <= i_n;
              j_q     <= j_n;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_READ_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);  // R8

  AST_ADDR_IN_REGION: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_req_o |-> (32'(mem_addr_o) < 32'(REGION_WORDS)));  // R9

  AST_QUIET_WHEN_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !mem_req_o);  // R6

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
    pass_o |-> done_o);  // R7

  AST_FAIL_RECORD_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && !pass_o && !start_i) |=> ($stable(fail_addr_o) && $stable(fail_act_o)));  // R6

endmodule

// File: tb/memtest_engine_tb_top.sv
`timescale 1ns/1ps
module memtest_engine_tb_top;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int RW = 300;
  localparam int RUN_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  always #2.5 clk = ~clk;

  logic          mem_req, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          done, pass;
  logic [1:0]    f_phase;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_exp, f_act;

  memtest_engine #(.AW(AW), .DW(DW), .REGION_WORDS(RW), .DBUS_ADDR(0)) dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid),
    .done_o(done), .pass_o(pass), .fail_phase_o(f_phase), .fail_addr_o(f_addr),
    .fail_exp_o(f_exp), .fail_act_o(f_act)
  );

  // memory model with fault knobs
  logic [DW-1:0] mem_m [0:(1<<AW)-1];
  logic [DW-1:0] s1_mask = '0, s0_mask = '0, cell_s0 = '0;
  logic [AW-1:0] alias_mask = '0, cell_addr = '0;
  logic          lat_var = 1'b0, lat_tog = 1'b0;
  logic          pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  int            cnt = 0;
  int            viol = 0, oob = 0;
  logic [8:0]    log_m [0:31];
  int            log_n = 0;
  logic          log_clr = 1'b0;

  function automatic logic [DW-1:0] faulty(input logic [DW-1:0] v, input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = (v | s1_mask) & ~s0_mask;
    if (a == cell_addr) r = r & ~cell_s0;
    return r;
  endfunction

  initial begin
    for (int k = 0; k < (1 << AW); k++) mem_m[k] = '0;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && mem_we) mem_m[mem_addr & ~alias_mask] <= mem_wdata;
    if (mem_req && 32'(mem_addr) >= RW) oob <= oob + 1;
    if (mem_req && pend) viol <= viol + 1;
    if (mem_req && !mem_we) begin
      pend    <= 1'b1;
      paddr   <= mem_addr & ~alias_mask;
      cnt     <= (lat_var && lat_tog) ? 4 : 1;
      lat_tog <= ~lat_tog;
    end else if (pend) begin
      if (cnt <= 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= faulty(mem_m[paddr], paddr);
        pend       <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
    if (log_clr) log_n <= 0;
    else if (mem_req && mem_addr == '0 && log_n < 32) begin
      log_m[log_n] <= mem_we ? {1'b1, mem_wdata} : 9'h000;
      log_n <= log_n + 1;
    end
  end

  int checks = 0, fails = 0, cyc_clean = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    s1_mask = '0; s0_mask = '0; cell_s0 = '0; alias_mask = '0; cell_addr = '0;
    lat_var = 1'b0;
  endtask

  task automatic run(input int poke_at, output int cyc);
    @(negedge clk); start = 1'b1; log_clr = 1'b1;
    @(negedge clk); start = 1'b0; log_clr = 1'b0;
    cyc = 1;
    while (!done && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke_at);
    end
    start = 1'b0;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual done 0 expected 1");
    end
  endtask

  task automatic expect_fail(input string req, input int ph, input int a, input int e, input int v);
    chk({req, " done"}, done, 1);
    chk({req, " pass"}, pass, 0);
    chk({req, " phase"}, f_phase, ph);
    chk({req, " addr"}, f_addr, a);
    chk({req, " expected"}, f_exp, e);
    chk({req, " actual"}, f_act, v);
  endtask

  task automatic t_reset();
    int seen = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (mem_req || done || pass) seen++;
    end
    chk("R11 idle after reset", seen, 0);
  endtask

  task automatic t_clean();
    int c;
    clear_faults();
    run(0, c);
    cyc_clean = c;
    chk("R7 clean pass", pass, 1);
    chk("R7 fail fields zero", {f_phase, f_addr, f_exp, f_act}, 0);
    chk("R1 first op write 0x01", log_m[0], 9'h101);
    chk("R1 read follows write", log_m[1], 9'h000);
    chk("R1 last walking one 0x80", log_m[14], 9'h180);
    chk("R2 first walking zero 0xFE", log_m[16], 9'h1FE);
    chk("R2 last walking zero 0x7F", log_m[30], 9'h17F);
    chk("R2 read follows write", log_m[31], 9'h000);
    chk("R5 word 299 complement", mem_m[299], 8'hD4);
    chk("R5 word 256 complement", mem_m[256], 8'hFF);
    chk("R4 truncated fill word 290", mem_m[290], 8'hDD);
    chk("R9 no access outside region", oob, 0);
    chk("R8 no overlap fixed latency", viol, 0);
  endtask

  task automatic t_latency();
    int c;
    clear_faults();
    lat_var = 1'b1;
    run(0, c);
    chk("R8 pass with varying latency", pass, 1);
    chk("R8 no overlap varying latency", viol, 0);
    lat_var = 1'b0;
  endtask

  task automatic t_busy_start();
    int c;
    clear_faults();
    run(500, c);
    chk("R10 start during run ignored, pass", pass, 1);
    chk("R10 start during run ignored, length", c, cyc_clean);
  endtask

  task automatic t_stuck_one();
    int c;
    clear_faults();
    s1_mask = 8'h08;
    run(0, c);
    expect_fail("R6 R1 stuck-1 bit3", 0, 0, 8'h01, 8'h09);
  endtask

  task automatic t_stuck_zero();
    int c;
    clear_faults();
    s0_mask = 8'h20;
    run(0, c);
    expect_fail("R1 stuck-0 bit5", 0, 0, 8'h20, 8'h00);
  endtask

  task automatic t_alias();
    int c;
    clear_faults();
    alias_mask = 10'h010;
    run(0, c);
    expect_fail("R3 address line 4 ignored", 1, 0, 8'hAA, 8'h55);
  endtask

  task automatic t_cell_fill();
    int c;
    clear_faults();
    cell_addr = 10'd123; cell_s0 = 8'h01;
    run(0, c);
    expect_fail("R4 cell 123", 2, 123, 8'h7B, 8'h7A);
    cell_addr = 10'd290; cell_s0 = 8'h02;
    run(0, c);
    expect_fail("R4 truncated cell 290", 2, 290, 8'h22, 8'h20);
  endtask

  task automatic t_cell_inv();
    int c;
    clear_faults();
    cell_addr = 10'd200; cell_s0 = 8'h01;
    run(0, c);
    expect_fail("R5 cell 200", 3, 200, 8'h37, 8'h36);
  endtask

  task automatic t_restart();
    int c;
    clear_faults();
    run(0, c);
    chk("R10 restart after fail passes", pass, 1);
    chk("R10 restart clears fail fields", {f_phase, f_addr, f_exp, f_act}, 0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_latency();
    t_busy_start();
    t_stuck_one();
    t_stuck_zero();
    t_alias();
    t_cell_fill();
    t_cell_inv();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: global timeout, actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule